// File: doc/BRIEF.md
# Stereo Playback Gain Stage with Soft Mute

This block scales the left and right 24-bit signed playback samples by a per-channel digital gain before they reach the interpolation filter. The applied gain is not switched abruptly. Each sample strobe moves it one fixed step toward its goal. The goal is zero while the path is muted and the channel's programmed gain otherwise. Mute is engaged out of reset, so the path stays silent until software releases it.

After scaling, each channel can be phase-inverted with saturation or forced to zero by its enable. An optional zero-run detector mutes both channels once the input has been silent on both channels for a long stretch. A bit selecting the downstream oversampling rate is held here and passed straight out.

Top module: `dac_gain_stage`

## Requirements
- R1: Out of reset the soft-mute bit is 1, the applied gains are 0, the polarity, zero-run-mute, oversampling and channel-enable bits are 0, `out_valid` is 0 and both outputs are 0. Samples sent before mute is released produce zero output.
- R2: While mute is requested, each sample strobe lowers the applied gain by `RAMP_STEP` until it reaches 0. It never goes below 0.
- R3: While mute is not requested, each strobe moves the applied gain by `RAMP_STEP` toward that channel's gain input. It lands exactly on the target and never passes it, also when the target changes during a ramp.
- R4: An output sample equals the input times the applied gain, shifted right arithmetically by `GAIN_FRAC`. The gain is unsigned and 1024 means unity by default. The result is clamped to the 24-bit signed range.
- R5: Control bit 0 inverts the left channel and bit 1 inverts the right. Inversion saturates, so the most negative scaled value becomes +8388607.
- R6: The enable register (`reg_addr`=1) holds the left enable in bit 0 and the right enable in bit 1. A disabled channel outputs 0.
- R7: When control bit 2 is set and 1024 consecutive strobes carry 0 on both channels, the ramp heads toward 0 exactly as in R2. The first strobe with any non-zero sample releases this mute. When bit 2 is clear, zero runs have no effect.
- R8: Control bit 3 (0 = 64x, 1 = 128x) appears on `osr_sel` the cycle after the write. It has no effect on the sample arithmetic.
- R9: `out_valid` and the outputs update at the clock edge that samples a strobe, and `out_valid` is 1 for that one following cycle. The output uses the gain applied before that strobe's ramp step. The gain changes only on strobes.
- R10: A write with `reg_addr`=0 loads control bits 0..3 and the soft-mute bit 6 (1 = mute, 0 = release). Bits 4 and 5 are ignored. A write takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 24 | Left input sample, signed |
| smp_right | input | 24 | Right input sample, signed |
| gain_left | input | GAIN_W | Left target gain, unsigned |
| gain_right | input | GAIN_W | Right target gain, unsigned |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = enable register |
| reg_wdata | input | 7 | Write data |
| out_valid | output | 1 | Output strobe |
| out_left | output | 24 | Left output sample |
| out_right | output | 24 | Right output sample |
| osr_sel | output | 1 | Oversampling select for the downstream filter |

## Verification
A sample presented with its strobe produces its result one clock later. That result uses the gain as it stood before the strobe. The ramp step caused by a strobe therefore first shows on the next strobe's result. Register writes change `osr_sel` and the arithmetic one edge after the write. Zero-run mute engages on the strobe after the 1024th silent one. The bench drives every input on a falling edge and predicts each result when it sends the sample. It pops and compares the result on the falling edge one cycle later, and checks there that `out_valid` arrived in exactly that cycle.

// File: rtl/dgs_pkg.sv
package dgs_pkg;
  localparam int SAMPLE_W = 24;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  localparam sample_t SMP_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam sample_t SMP_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

  typedef struct packed {
    logic softmute;
    logic osr;
    logic zmute_en;
    logic inv_r;
    logic inv_l;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{softmute: 1'b1, osr: 1'b0, zmute_en: 1'b0,
                                   inv_r: 1'b0, inv_l: 1'b0};

  // negation clamped so that the most negative value maps to the most positive
  function automatic sample_t negate_sat(sample_t x);
    return (x == SMP_MIN) ? SMP_MAX : -x;
  endfunction
endpackage

// File: rtl/dgs_ctrl_regs.sv
module dgs_ctrl_regs
  import dgs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [6:0]  reg_wdata,
  output ctrl_t       ctrl,
  output logic [1:0]  ch_en
);
  logic [1:0] unused_wbits;
  assign unused_wbits = reg_wdata[5:4];

  logic wr_ctrl, wr_en;
  assign wr_ctrl = reg_wr && !reg_addr;
  assign wr_en   = reg_wr &&  reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RESET;
      ch_en <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.inv_l    <= reg_wdata[0];
        ctrl.inv_r    <= reg_wdata[1];
        ctrl.zmute_en <= reg_wdata[2];
        ctrl.osr      <= reg_wdata[3];
        ctrl.softmute <= reg_wdata[6];
      end
      if (wr_en) ch_en <= reg_wdata[1:0];
    end
  end

  // R10: soft-mute bit follows the written bit 6
  a_r10_softmute_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl.softmute == $past(reg_wdata[6]));
  // R6: enable register untouched by control writes
  a_r6_enable_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> $stable(ch_en));
endmodule

// File: rtl/dgs_zero_watch.sv
module dgs_zero_watch
  import dgs_pkg::*;
#(
  parameter int ZERO_RUN = 1024
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    smp_valid,
  input  sample_t smp_l,
  input  sample_t smp_r,
  input  logic    zmute_en,
  output logic    zmute_active
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] RUN_END = CW'(ZERO_RUN);

  logic [CW-1:0] run_cnt;
  logic          both_zero;
  logic          run_full;

  assign both_zero = (smp_l == '0) && (smp_r == '0);
  assign run_full  = (run_cnt == RUN_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (smp_valid) begin
      if (!both_zero)    run_cnt <= '0;
      else if (!run_full) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign zmute_active = zmute_en && run_full;

  // R7: a non-zero sample releases zero-run mute at once
  a_r7_release_on_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !both_zero) |=> !zmute_active);
  // R7: zero-run mute never active while disabled
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    zmute_active |-> zmute_en);
endmodule

// File: rtl/dgs_gain_ramp.sv
module dgs_gain_ramp #(
  parameter int GAIN_W    = 12,
  parameter int RAMP_STEP = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              mute_req,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] cur_gain
);
  localparam logic [GAIN_W-1:0] STEP_V = GAIN_W'(RAMP_STEP);

  function automatic logic [GAIN_W-1:0] step_toward(logic [GAIN_W-1:0] cur,
                                                    logic [GAIN_W-1:0] goal);
    if (cur < goal)
      return ((goal - cur) <= STEP_V) ? goal : cur + STEP_V;
    else if (cur > goal)
      return ((cur - goal) <= STEP_V) ? goal : cur - STEP_V;
    else
      return cur;
  endfunction

  logic [GAIN_W-1:0] goal, next_gain;
  assign goal      = mute_req ? '0 : target;
  assign next_gain = step_toward(cur_gain, goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_gain <= '0;
    else if (smp_valid) cur_gain <= next_gain;
  end

  // R2/R3: no more than one step per strobe
  a_r3_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_valid) |-> (((cur_gain >= $past(cur_gain)) ? (cur_gain - $past(cur_gain))
                                                          : ($past(cur_gain) - cur_gain)) <= STEP_V));
  // R3: rising ramp never passes the target
  a_r3_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !mute_req && cur_gain <= target) |=> cur_gain <= $past(target));
  // R2: muted and at zero stays at zero
  a_r2_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req && cur_gain == '0) |=> cur_gain == '0);
  // R9: gain moves only on strobes
  a_r9_gain_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(cur_gain));
endmodule

// File: rtl/dgs_chan_out.sv
module dgs_chan_out
  import dgs_pkg::*;
#(
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  sample_t           sample_in,
  input  logic [GAIN_W-1:0] gain,
  input  logic              invert,
  input  logic              enable,
  output sample_t           sample_out
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] HI = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = ~HI;

  function automatic sample_t scale_sat(sample_t s, logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    prod = $signed(s) * $signed({1'b0, g});
    shf  = prod >>> GAIN_FRAC;
    if (shf > HI)      return SMP_MAX;
    else if (shf < LO) return SMP_MIN;
    else               return shf[SAMPLE_W-1:0];
  endfunction

  sample_t scaled, shaped;
  assign scaled = scale_sat(sample_in, gain);
  assign shaped = invert ? negate_sat(scaled) : scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sample_out <= '0;
    else if (smp_valid) sample_out <= enable ? shaped : '0;
  end

  // R6: disabled channel emits zero
  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !enable) |=> sample_out == '0);
  // R5: inverted output never reaches the most negative code
  a_r5_invert_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && enable && invert) |=> sample_out != SMP_MIN);
  // R4: zero gain gives zero output
  a_r4_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && gain == '0) |=> sample_out == '0);
endmodule

// File: rtl/dac_gain_stage.sv
module dac_gain_stage
  import dgs_pkg::*;
#(
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 10,
  parameter int RAMP_STEP = 64,
  parameter int ZERO_RUN  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [23:0]       smp_left,
  input  logic [23:0]       smp_right,
  input  logic [GAIN_W-1:0] gain_left,
  input  logic [GAIN_W-1:0] gain_right,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [6:0]        reg_wdata,
  output logic              out_valid,
  output logic [23:0]       out_left,
  output logic [23:0]       out_right,
  output logic              osr_sel
);
  localparam int NCH = 2;

  ctrl_t      ctrl;
  logic [1:0] ch_en;
  logic       zmute_active;
  logic       mute_req;

  dgs_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl      (ctrl),
    .ch_en     (ch_en)
  );

  dgs_zero_watch #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .smp_l        (sample_t'(smp_left)),
    .smp_r        (sample_t'(smp_right)),
    .zmute_en     (ctrl.zmute_en),
    .zmute_active (zmute_active)
  );

  assign mute_req = ctrl.softmute || zmute_active;

  sample_t           ch_in  [NCH];
  sample_t           ch_out [NCH];
  logic [GAIN_W-1:0] ch_tgt [NCH];
  logic [GAIN_W-1:0] ch_gain[NCH];
  logic [NCH-1:0]    ch_inv;

  assign ch_in[0]  = sample_t'(smp_left);
  assign ch_in[1]  = sample_t'(smp_right);
  assign ch_tgt[0] = gain_left;
  assign ch_tgt[1] = gain_right;
  assign ch_inv    = {ctrl.inv_r, ctrl.inv_l};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dgs_gain_ramp #(.GAIN_W(GAIN_W), .RAMP_STEP(RAMP_STEP)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .mute_req  (mute_req),
      .target    (ch_tgt[c]),
      .cur_gain  (ch_gain[c])
    );
    dgs_chan_out #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .sample_in  (ch_in[c]),
      .gain       (ch_gain[c]),
      .invert     (ch_inv[c]),
      .enable     (ch_en[c]),
      .sample_out (ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign osr_sel   = ctrl.osr;

  // R9: one result per strobe, one cycle later
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  // R8: oversampling select only moves on a control write
  a_r8_osr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr) |=> $stable(osr_sel));
endmodule

// File: tb/dac_gain_stage_test.sv
module dac_gain_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic [11:0] gain_left = '0, gain_right = '0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [6:0]  reg_wdata = '0;
  logic        out_valid, osr_sel;
  logic [23:0] out_left, out_right;

  always #10 clk = ~clk;

  dac_gain_stage uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .gain_left(gain_left), .gain_right(gain_right),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .osr_sel(osr_sel)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // reference state
  int m_cur[2];
  bit m_inv[2];
  bit m_en[2];
  bit m_soft = 1;
  bit m_zen  = 0;
  int m_run  = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_out(int s, int g, bit inv, bit en);
    longint v;
    if (!en) return 24'd0;
    v = longint'(s) * longint'(g);
    v = v / 1024 - ((v < 0 && (v % 1024) != 0) ? 1 : 0);  // floor division
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    if (inv) v = (v == -8388608) ? 8388607 : -v;
    return v[23:0];
  endfunction

  task automatic wr(bit addr, int data);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = data[6:0];
    @(negedge clk);
    reg_wr = 1'b0;
    if (!addr) begin
      m_inv[0] = data[0]; m_inv[1] = data[1];
      m_zen = data[2]; m_soft = data[6];
    end else begin
      m_en[0] = data[0]; m_en[1] = data[1];
    end
  endtask

  task automatic send(int l, int r, string tag);
    exp_t e;
    int   g[2];
    int   goal;
    bit   mute;
    e.l = ref_out(l, m_cur[0], m_inv[0], m_en[0]);
    e.r = ref_out(r, m_cur[1], m_inv[1], m_en[1]);
    e.tag = tag;
    exp_q.push_back(e);
    g[0] = int'(gain_left); g[1] = int'(gain_right);
    mute = m_soft || (m_zen && m_run == 1024);
    for (int c = 0; c < 2; c++) begin
      goal = mute ? 0 : g[c];
      if (m_cur[c] + 64 <= goal) m_cur[c] += 64;
      else if (m_cur[c] - 64 >= goal) m_cur[c] -= 64;
      else m_cur[c] = goal;
    end
    if (l != 0 || r != 0) m_run = 0;
    else if (m_run < 1024) m_run++;
    smp_left = l[23:0]; smp_right = r[23:0]; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R9 out_valid one cycle after strobe", longint'(out_valid), 1);
    @(negedge clk);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected out_valid", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " left"},  longint'($signed(out_left)),  longint'($signed(e.l)));
        chk({e.tag, " right"}, longint'($signed(out_right)), longint'($signed(e.r)));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_cur[0] = 0; m_cur[1] = 0;
    m_inv[0] = 0; m_inv[1] = 0; m_en[0] = 0; m_en[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 out_left", longint'(out_left), 0);
    chk("R1 out_right", longint'(out_right), 0);
    chk("R1 osr_sel", longint'(osr_sel), 0);
    gain_left = 12'd1024; gain_right = 12'd1024;
    wr(1, 3);
    for (int i = 0; i < 3; i++) send(5000, -5000, "R1 muted");

    // R10 release mute, R3 ramp up to programmed gain
    wr(0, 0);
    for (int i = 0; i < 20; i++) send(1000, -2000, "R3 ramp up");

    // R4 scaling and clamping
    send(8388607, -8388608, "R4 unity extremes");
    send(12345, -777, "R4 unity");
    gain_left = 12'd3000; gain_right = 12'd512;
    for (int i = 0; i < 40; i++) send(4000000, -4000000, "R4 saturate");

    // R3 target change mid-ramp
    gain_left = 12'd2000; gain_right = 12'd2000;
    for (int i = 0; i < 5; i++) send(7777, -3333, "R3 retarget");
    gain_left = 12'd1100; gain_right = 12'd900;
    for (int i = 0; i < 20; i++) send(7777, -3333, "R3 retarget");

    // R5 polarity with saturation
    wr(0, 3);
    send(-8388608, 100, "R5 invert");
    send(300, -8388608, "R5 invert");
    send(-4096, 4096, "R5 invert");
    wr(0, 1);
    send(-4096, 4096, "R5 left only");

    // R6 channel enables
    wr(1, 2);
    for (int i = 0; i < 3; i++) send(50000, 50000, "R6 left disabled");
    wr(1, 1);
    send(50000, 50000, "R6 right disabled");
    wr(1, 3);

    // R8 oversampling select, R10 bits 4,5 ignored
    wr(0, 'h38);
    chk("R8 osr_sel set", longint'(osr_sel), 1);
    send(60000, -60000, "R8 no arithmetic effect");
    send(60000, -60000, "R10 ignored bits");

    // R2 soft mute ramp down
    wr(0, 'h48);
    for (int i = 0; i < 25; i++) send(100000, -100000, "R2 ramp down");
    chk("R8 osr_sel kept", longint'(osr_sel), 1);

    // R7 zero runs ignored when disabled
    gain_left = 12'd1024; gain_right = 12'd1024;
    wr(0, 0);
    chk("R8 osr_sel cleared", longint'(osr_sel), 0);
    for (int i = 0; i < 20; i++) send(200, 300, "R7 ramp");
    for (int i = 0; i < 1100; i++) send(0, 0, "R7 zeros off");
    for (int i = 0; i < 3; i++) send(50000, -50000, "R7 disabled no mute");

    // R7 zero-run mute enabled
    wr(0, 4);
    for (int i = 0; i < 1100; i++) send(0, 0, "R7 zeros on");
    for (int i = 0; i < 20; i++) send(50000, -50000, "R7 release ramp");

    repeat (5) @(negedge clk);
    chk("R9 scoreboard drained", longint'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule